// File: doc/BRIEF.md
# On-Time Current Sample Averager

This block watches a stream of digitized current-sense codes during the active on-time of each PWM half-cycle. At the start of a pulse it ignores a fixed blanking window, so that switching spikes are not counted. After that window it adds every valid sample into a running total and counts the samples. When the pulse ends, the total times four is divided by the count, and the result is written to a registered output together with a one-cycle update strobe. Between updates the output stays fixed.

The same post-blanking sample stream drives a peak-limit comparator. Any qualified sample above a fixed threshold code raises the overcurrent flag in the same cycle, so surrounding logic can end the pulse at once. A blanked sample never raises it. The accumulator clears at the end of every pulse, so each result covers one pulse only. A pulse that ends before any post-blanking sample arrives leaves the output and strobe untouched.

Top module: `oca_top`

## Requirements
- R1: While reset is asserted (rst_n low) and right after it, avg_out reads 0, avg_upd reads 0 and ovc_flag reads 0.
- R2: A pulse's cycle index is the number of earlier consecutive cycles in which pulse_on was 1 (the first high cycle has index 0). Samples at indices 0 to BLANK_CYC-1 (default 14) count toward neither the average nor the overcurrent flag.
- R3: A qualified sample is one with pulse_on=1, smp_vld=1 and index at least BLANK_CYC. The published value is floor(4 x sum of qualified codes / number of qualified codes) for that pulse, clipped to 2^OUT_W-1.
- R4: A pulse ends in the first cycle in which pulse_on is 0 after a cycle in which it was 1. The new value appears on avg_out, and avg_upd is 1 for exactly one cycle, LAT = SENSE_W+CNT_W+2 (default 24) clock edges after the edge that samples that low level. At all other times avg_out holds its value.
- R5: A pulse with no qualified samples produces no update strobe, and avg_out keeps its previous value.
- R6: The sum and the count restart at zero for every pulse, so a result does not depend on earlier pulses.
- R7: ovc_flag is combinational. It is 1 in exactly those cycles that present a qualified sample whose code is strictly greater than PEAK_CODE (default 2048).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_on | input | 1 | High while the PWM pulse is active |
| smp_vld | input | 1 | Sense sample present this cycle |
| smp_code | input | SENSE_W (12) | Current-sense code |
| avg_out | output | OUT_W (14) | Held four-times average of the last pulse |
| avg_upd | output | 1 | One-cycle strobe marking a new avg_out |
| ovc_flag | output | 1 | Peak overcurrent flag, same cycle as the sample |

## Verification
The overcurrent flag is due in the same cycle as the sample that causes it. The bench therefore compares it half a cycle after the inputs change, using the blanking index its model has counted. An average is due exactly LAT edges after the edge that sees the pulse end. The model schedules the expected value and strobe at that cycle number and compares avg_out and avg_upd on every falling edge, so a result that arrives one cycle early or late is caught. Fixed-value checks after each dead time confirm the hand-computed averages, the per-pulse restart, and that a pulse with no qualified samples changes nothing.

// File: rtl/oca_pkg.sv
package oca_pkg;
  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/oca_blank_gate.sv
module oca_blank_gate #(
  parameter int BLANK_CYC = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_on,
  input  logic smp_vld,
  output logic blanked,
  output logic qual,
  output logic pulse_end
);
  localparam int AGE_W = $clog2(BLANK_CYC + 1);
  localparam logic [AGE_W-1:0] BLANK_V = AGE_W'(BLANK_CYC);

  logic             on_q;
  logic [AGE_W-1:0] age_q;
  logic [AGE_W-1:0] age_nx;

  // age counts earlier high cycles of this pulse, saturating at the window
  always_comb begin
    if (!pulse_on)           age_nx = '0;
    else if (age_q == BLANK_V) age_nx = age_q;
    else                     age_nx = age_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      age_q <= '0;
    end else begin
      on_q  <= pulse_on;
      age_q <= age_nx;
    end
  end

  assign blanked   = pulse_on && (age_q < BLANK_V);
  assign qual      = pulse_on && !blanked && smp_vld;
  assign pulse_end = on_q && !pulse_on;
endmodule

// File: rtl/oca_accum.sv
module oca_accum #(
  parameter int SENSE_W = 12,
  parameter int CNT_W   = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     qual,
  input  logic                     pulse_end,
  input  logic [SENSE_W-1:0]       smp_code,
  output logic [SENSE_W+CNT_W-1:0] sum_o,
  output logic [CNT_W-1:0]         cnt_o,
  output logic                     snap_ok
);
  localparam int SUM_W = SENSE_W + CNT_W;

  logic [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_full;

  assign cnt_full = &cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || pulse_end) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (qual && !cnt_full) begin
      sum_q <= sum_q + {{CNT_W{1'b0}}, smp_code};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sum_o   = sum_q;
  assign cnt_o   = cnt_q;
  assign snap_ok = pulse_end && (cnt_q != '0);

  AST_RESTART_EACH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_end |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/oca_divider.sv
module oca_divider
  import oca_pkg::*;
#(
  parameter int NUM_W = 24,
  parameter int DEN_W = 10,
  parameter int OUT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [OUT_W-1:0] avg_o,
  output logic             upd_o
);
  localparam int STEP_W = $clog2(NUM_W + 1);
  localparam int PAIR_W = DEN_W + 1 + NUM_W;
  localparam logic [NUM_W-1:0] MAXQ = {{(NUM_W-OUT_W){1'b0}}, {OUT_W{1'b1}}};

  // one restoring step: shift remainder/quotient left, subtract if it fits
  function automatic logic [PAIR_W-1:0] div_step(
    input logic [DEN_W:0]   rem,
    input logic [NUM_W-1:0] quo,
    input logic [DEN_W-1:0] d
  );
    logic [DEN_W:0]   r;
    logic [NUM_W-1:0] q;
    r = {rem[DEN_W-1:0], quo[NUM_W-1]};
    q = {quo[NUM_W-2:0], 1'b0};
    if (r >= {1'b0, d}) begin
      r    = r - {1'b0, d};
      q[0] = 1'b1;
    end
    return {r, q};
  endfunction

  function automatic logic [OUT_W-1:0] clip(input logic [NUM_W-1:0] q);
    if (q > MAXQ) return {OUT_W{1'b1}};
    return q[OUT_W-1:0];
  endfunction

  div_state_e        st_q;
  logic [DEN_W:0]    rem_q;
  logic [NUM_W-1:0]  quo_q;
  logic [DEN_W-1:0]  den_q;
  logic [STEP_W-1:0] step_q;
  logic [PAIR_W-1:0] nxt;
  logic [DEN_W:0]    rem_nx;
  logic [NUM_W-1:0]  quo_nx;
  logic              last_step;

  assign nxt       = div_step(rem_q, quo_q, den_q);
  assign rem_nx    = nxt[PAIR_W-1:NUM_W];
  assign quo_nx    = nxt[NUM_W-1:0];
  assign last_step = (st_q == DIV_RUN) && (step_q == STEP_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= DIV_IDLE;
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      step_q <= '0;
      avg_o  <= '0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (load) begin
        st_q   <= DIV_RUN;
        rem_q  <= '0;
        quo_q  <= num;
        den_q  <= den;
        step_q <= STEP_W'(NUM_W);
      end else if (st_q == DIV_RUN) begin
        rem_q  <= rem_nx;
        quo_q  <= quo_nx;
        step_q <= step_q - 1'b1;
        if (last_step) begin
          st_q  <= DIV_IDLE;
          avg_o <= clip(quo_nx);
          upd_o <= 1'b1;
        end
      end
    end
  end

  AST_LOAD_HAS_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (den != '0)); // R5
  AST_HOLD_BETWEEN_UPDATES: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> $stable(avg_o)); // R4
endmodule

// File: rtl/oca_peak.sv
module oca_peak #(
  parameter int SENSE_W   = 12,
  parameter int PEAK_CODE = 2048
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               qual,
  input  logic               blanked,
  input  logic [SENSE_W-1:0] smp_code,
  output logic               ovc
);
  localparam logic [SENSE_W-1:0] PEAK_V = SENSE_W'(PEAK_CODE);

  assign ovc = qual && (smp_code > PEAK_V);

  AST_NO_FLAG_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    ovc |-> !blanked); // R2
endmodule

// File: rtl/oca_top.sv
module oca_top #(
  parameter int SENSE_W   = 12,
  parameter int OUT_W     = 14,
  parameter int CNT_W     = 10,
  parameter int BLANK_CYC = 14,
  parameter int PEAK_CODE = 2048
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pulse_on,
  input  logic               smp_vld,
  input  logic [SENSE_W-1:0] smp_code,
  output logic [OUT_W-1:0]   avg_out,
  output logic               avg_upd,
  output logic               ovc_flag
);
  localparam int SUM_W = SENSE_W + CNT_W;
  localparam int NUM_W = SUM_W + 2;

  logic             blanked;
  logic             qual;
  logic             pulse_end;
  logic [SUM_W-1:0] sum_w;
  logic [CNT_W-1:0] cnt_w;
  logic             snap_ok;

  oca_blank_gate #(.BLANK_CYC(BLANK_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .pulse_on(pulse_on), .smp_vld(smp_vld),
    .blanked(blanked), .qual(qual), .pulse_end(pulse_end)
  );

  oca_accum #(.SENSE_W(SENSE_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .qual(qual), .pulse_end(pulse_end),
    .smp_code(smp_code), .sum_o(sum_w), .cnt_o(cnt_w), .snap_ok(snap_ok)
  );

  oca_divider #(.NUM_W(NUM_W), .DEN_W(CNT_W), .OUT_W(OUT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(snap_ok), .num({sum_w, 2'b00}),
    .den(cnt_w), .avg_o(avg_out), .upd_o(avg_upd)
  );

  oca_peak #(.SENSE_W(SENSE_W), .PEAK_CODE(PEAK_CODE)) u_peak (
    .clk(clk), .rst_n(rst_n), .qual(qual), .blanked(blanked),
    .smp_code(smp_code), .ovc(ovc_flag)
  );

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    avg_upd |=> !avg_upd); // R4
  AST_FLAG_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovc_flag |-> (pulse_on && smp_vld)); // R7
endmodule

// File: tb/sim_oca_top.sv
`timescale 1ns/1ps
module sim_oca_top;
  localparam int BLANK = 14;
  localparam int PEAK  = 2048;
  localparam int LAT   = 24;
  localparam int OMAX  = 16383;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulse_on = 1'b0;
  logic        smp_vld = 1'b0;
  logic [11:0] smp_code = '0;
  logic [13:0] avg_out;
  logic        avg_upd;
  logic        ovc_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int run = 0, sum = 0, cnt = 0;
  int due = -1, upd_at = -1, pend = 0, exp_avg = 0;
  int n_upd = 0, n_ovc = 0;
  bit live = 1'b0;

  oca_top u0 (
    .clk(clk), .rst_n(rst_n), .pulse_on(pulse_on), .smp_vld(smp_vld),
    .smp_code(smp_code), .avg_out(avg_out), .avg_upd(avg_upd), .ovc_flag(ovc_flag)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      run = 0; sum = 0; cnt = 0;
    end else begin
      if (cyc == due) begin
        exp_avg = pend;
        upd_at  = cyc;
      end
      if (pulse_on) begin
        if (smp_vld && run >= BLANK) begin
          sum += int'(smp_code);
          cnt++;
        end
        run++;
      end else begin
        if (run > 0 && cnt > 0) begin
          pend = (4 * sum) / cnt;
          if (pend > OMAX) pend = OMAX;
          due = cyc + LAT;
        end
        run = 0; sum = 0; cnt = 0;
      end
    end
    if (cyc > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 50000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // compare every cycle, half a period after inputs settle
  always @(negedge clk) begin
    if (live) begin
      bit eo;
      eo = pulse_on && smp_vld && (run >= BLANK) && (int'(smp_code) > PEAK);
      chk((pulse_on && run < BLANK) ? "R2 blanked flag" : "R7 overcurrent",
          int'(ovc_flag), int'(eo));
      chk("R4 strobe timing", int'(avg_upd), int'(upd_at == cyc));
      chk("R3 held average", int'(avg_out), exp_avg);
      if (avg_upd) n_upd++;
      if (ovc_flag) n_ovc++;
    end
  end

  task automatic step(input bit on, input bit vld, input int code);
    @(posedge clk);
    #1;
    pulse_on = on;
    smp_vld  = vld;
    smp_code = 12'(code);
  endtask

  task automatic run_pulse(input int len, input int base, input int incr, input int every);
    for (int i = 0; i < len; i++) step(1'b1, (i % every) == 0, base + i * incr);
  endtask

  task automatic dead(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0);
  endtask

  initial begin
    int n0;
    int a0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 reset avg", int'(avg_out), 0);
    chk("R1 reset upd", int'(avg_upd), 0);
    chk("R1 reset ovc", int'(ovc_flag), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    live = 1'b1;
    dead(3);
    @(negedge clk);
    chk("R1 after reset avg", int'(avg_out), 0);

    // constant 1000: 26 qualified samples, 4*1000
    run_pulse(40, 1000, 0, 1);
    dead(30);
    @(negedge clk); chk("R3 constant pulse", int'(avg_out), 4000);

    // next pulse 500 must not inherit the previous total
    run_pulse(40, 500, 0, 1);
    dead(30);
    @(negedge clk); chk("R6 fresh accumulation", int'(avg_out), 2000);

    // pulse shorter than blanking: no strobe, value kept, no flag
    n0 = n_upd; a0 = n_ovc;
    run_pulse(10, 4000, 0, 1);
    dead(30);
    @(negedge clk);
    chk("R5 no strobe", n_upd, n0);
    chk("R5 value held", int'(avg_out), 2000);
    chk("R2 no flag in blank", n_ovc, a0);

    // spike inside blanking ignored, spike after blanking flagged
    a0 = n_ovc;
    for (int i = 0; i < 40; i++)
      step(1'b1, 1'b1, (i == 2 || i == 20) ? 3000 : 0);
    dead(30);
    @(negedge clk);
    chk("R7 single flag", n_ovc, a0 + 1);
    chk("R2 blanked spike excluded", int'(avg_out), 461);

    // full-scale code
    run_pulse(30, 4095, 0, 1);
    dead(30);
    @(negedge clk); chk("R3 full scale", int'(avg_out), 16380);

    // threshold edge: equal code does not flag
    a0 = n_ovc;
    run_pulse(20, 2048, 0, 1);
    dead(30);
    @(negedge clk);
    chk("R7 equal to threshold", n_ovc, a0);
    chk("R3 threshold pulse", int'(avg_out), 8192);

    // ramp and sparse patterns, checked by the model every cycle
    run_pulse(60, 100, 37, 1);
    dead(26);
    run_pulse(50, 1500, 5, 3);
    dead(26);
    run_pulse(15, 700, 0, 1);
    dead(30);
    @(negedge clk); chk("R3 single qualified sample", int'(avg_out), 2800);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule